// File: doc/BRIEF.md
# Burst Column Address Generator

This block walks through the column addresses of one synchronous DRAM read or write burst inside an already open row. A controller pulses a start strobe together with a start column, a burst-length code and an ordering select. From the next clock on, the block presents one column address per cycle, with a valid flag. A last flag marks the final beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block that contains the start column. The addresses follow either a wrapping increment or an XOR-based interleave. The full-page setting steps through the entire 8-bit column space in increasing order and wraps from the top column to zero. It keeps going until the controller raises the stop input. A stop input can also cut any burst short, and a fresh start strobe replaces a burst that is still running.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `valid_o` and `last_o` are low.
- R2: In the cycle after a start strobe is sampled, `valid_o` is high and `col_o` equals the sampled start column.
- R3: Once a burst begins, `valid_o` stays high on every consecutive cycle, with one new address per clock, until the burst ends.
- R4: Length codes on `blen_i` select the beat count: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. `last_o` is high only on the final beat, and `valid_o` is low in the cycle after it.
- R5: With `btype_i`=0 (sequential) and N beats, beat k carries the start column with its low log2(N) bits replaced by (low bits + k) mod N. The upper bits are unchanged.
- R6: With `btype_i`=1 (interleave) and N beats, beat k carries the start column with its low log2(N) bits XORed with k.
- R7: Length codes 4 to 7 select full page. Beat k is (start + k) mod 256 whatever `btype_i` is, `last_o` is never raised, and the burst continues past 256 beats.
- R8: A high `stop_i` sampled during a burst makes `valid_o` low in the next cycle. When idle, `stop_i` has no effect.
- R9: A start strobe sampled during a burst, or in the same cycle as `stop_i`, begins a new burst from the new column and mode in the next cycle.
- R10: For a length-1 burst, `valid_o` and `last_o` are high together in a single cycle.
- R11: `blen_i`, `btype_i` and `start_col_i` are used only in the cycle a start strobe is sampled. Changing them during a burst does not alter its addresses or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | 8 | Column of the first beat |
| blen_i | input | 3 | Burst-length code (0:1, 1:2, 2:4, 3:8, 4-7: full page) |
| btype_i | input | 1 | Ordering: 0 sequential, 1 interleave |
| stop_i | input | 1 | Terminates the running burst |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
On every cycle, the assertions check the control behaviour visible at the ports. They check the first beat after a start, the unbroken run of beats, the end of the burst after last or a stop, the coupling of last to valid, the single-beat burst, and the plus-one step of full-page addresses. The bench checks which address appears at which beat for each ordering, across every start column and fixed length. It also covers full-page wrap past 256 beats, restart in mid-burst, and the fact that mode inputs are ignored after the start. These depend on the whole stimulus history rather than on one cycle.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    localparam int COL_W = 8;
    localparam int LG_W  = 2;

    typedef enum logic [2:0] {
        BLEN_1    = 3'd0,
        BLEN_2    = 3'd1,
        BLEN_4    = 3'd2,
        BLEN_8    = 3'd3,
        BLEN_PAGE = 3'd4
    } blen_code_e;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } order_e;

    typedef struct packed {
        logic            page;
        order_e          order;
        logic [LG_W-1:0] lg;
    } burst_cfg_t;

    // Codes with bit 2 set select full page, which always runs in sequential order
    function automatic burst_cfg_t decode_cfg(input logic [2:0] code, input logic typ);
        burst_cfg_t c;
        c.page  = code[2];
        c.order = code[2] ? ORD_SEQ : order_e'(typ);
        c.lg    = code[LG_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
    import burst_col_pkg::*;
#(
    parameter int CNT_W = COL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  burst_cfg_t       cfg_i,
    output logic             active_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);

    logic [CNT_W-1:0] final_cnt;

    assign final_cnt = (CNT_W'(1) << cfg_i.lg) - CNT_W'(1);
    assign last_o    = active_o && !cfg_i.page && (cnt_o == final_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o <= 1'b0;
            cnt_o    <= '0;
        end else if (start_i) begin
            active_o <= 1'b1;
            cnt_o    <= '0;
        end else if (active_o) begin
            if (stop_i || last_o) begin
                active_o <= 1'b0;
            end
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/burst_col_order.sv
module burst_col_order
    import burst_col_pkg::*;
#(
    parameter int COL_WIDTH = COL_W
) (
    input  logic [COL_WIDTH-1:0] base_i,
    input  logic [COL_WIDTH-1:0] cnt_i,
    input  burst_cfg_t           cfg_i,
    output logic [COL_WIDTH-1:0] col_o
);

    logic [COL_WIDTH-1:0] wrap_mask;
    logic [COL_WIDTH-1:0] seq_col;
    logic [COL_WIDTH-1:0] intlv_col;

    // Bits that move during the burst; the rest hold the aligned block
    always_comb begin
        for (int i = 0; i < COL_WIDTH; i++) begin
            wrap_mask[i] = cfg_i.page || (i < int'(cfg_i.lg));
        end
    end

    assign seq_col   = (base_i & ~wrap_mask) | ((base_i + cnt_i) & wrap_mask);
    assign intlv_col = base_i ^ (cnt_i & wrap_mask);
    assign col_o     = (cfg_i.order == ORD_INTLV) ? intlv_col : seq_col;

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_WIDTH = COL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [COL_WIDTH-1:0] start_col_i,
    input  logic [2:0]           blen_i,
    input  logic                 btype_i,
    input  logic                 stop_i,
    output logic [COL_WIDTH-1:0] col_o,
    output logic                 valid_o,
    output logic                 last_o
);

    burst_cfg_t           cfg_q;
    logic [COL_WIDTH-1:0] base_q;
    logic [COL_WIDTH-1:0] beat_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            base_q <= '0;
        end else if (start_i) begin
            cfg_q  <= decode_cfg(blen_i, btype_i);
            base_q <= start_col_i;
        end
    end

    burst_col_ctrl #(
        .CNT_W (COL_WIDTH)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .cfg_i    (cfg_q),
        .active_o (valid_o),
        .cnt_o    (beat_cnt),
        .last_o   (last_o)
    );

    burst_col_order #(
        .COL_WIDTH (COL_WIDTH)
    ) u_order (
        .base_i (base_q),
        .cnt_i  (beat_cnt),
        .cfg_i  (cfg_q),
        .col_o  (col_o)
    );

endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
    parameter int COL_WIDTH = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start_i,
    input logic [COL_WIDTH-1:0] start_col_i,
    input logic [2:0]           blen_i,
    input logic                 stop_i,
    input logic [COL_WIDTH-1:0] col_o,
    input logic                 valid_o,
    input logic                 last_o
);

    logic page_seen;

    always_ff @(posedge clk) begin
        if (rst) page_seen <= 1'b0;
        else if (start_i) page_seen <= blen_i[2];
    end

    AST_LAST_IMPLIES_VALID: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o); // R4

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (valid_o && col_o == $past(start_col_i))); // R2

    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !stop_i) |=> valid_o); // R3

    AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (valid_o && last_o && !start_i) |=> !valid_o); // R4

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !start_i) |=> !valid_o); // R8

    AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (rst)
        (start_i && blen_i == 3'd0) |=> (valid_o && last_o)); // R10

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        (valid_o && page_seen && !start_i && !stop_i) |=>
            (valid_o && !last_o && col_o == COL_WIDTH'($past(col_o) + 1'b1))); // R7

endmodule

bind burst_col_gen burst_col_chk #(.COL_WIDTH(COL_WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .blen_i      (blen_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] blen_i = '0;
    logic       btype_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o;
    logic       last_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    burst_col_gen i_burst_col_gen (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .blen_i      (blen_i),
        .btype_i     (btype_i),
        .stop_i      (stop_i),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_col(input int s, input int code, input int typ, input int k);
        int n;
        int low;
        n   = 1 << code;
        low = (typ == 0) ? ((s % n) + k) % n : ((s % n) ^ k);
        return s - (s % n) + low;
    endfunction

    // drives a start at the current negedge; returns at the negedge showing beat 0
    task automatic launch(input int col, input int code, input int typ);
        start_col_i = 8'(col);
        blen_i      = 3'(code);
        btype_i     = typ[0];
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!valid_o && !last_o, "R1 reset", int'(valid_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!valid_o && !last_o, "R1 after reset", int'(valid_o), 0);

        // Sweep: every start column, every fixed length, both orders; mode inputs scrambled after start
        for (int code = 0; code < 4; code++) begin
            for (int typ = 0; typ < 2; typ++) begin
                for (int s = 0; s < 256; s++) begin
                    launch(s, code, typ);
                    blen_i      = 3'(~code);
                    btype_i     = ~typ[0];
                    start_col_i = 8'(~s);
                    for (int k = 0; k < (1 << code); k++) begin
                        int e;
                        e = exp_col(s, code, typ, k);
                        chk(valid_o == 1'b1, "R3 valid in burst", int'(valid_o), 1);
                        chk(int'(col_o) == e, typ ? "R6/R11 interleave col" : "R5/R11 sequential col",
                            int'(col_o), e);
                        chk(last_o == (k == (1 << code) - 1),
                            code == 0 ? "R10 single beat last" : "R4 last flag",
                            int'(last_o), int'(k == (1 << code) - 1));
                        @(negedge clk);
                    end
                    chk(!valid_o, "R4 idle after last", int'(valid_o), 0);
                end
            end
        end

        // Full page: interleave select ignored, wraps past 255, runs beyond 256 beats
        launch(250, 5, 1);
        for (int k = 0; k < 300; k++) begin
            chk(valid_o && !last_o, "R7 page valid no last", int'(last_o), 0);
            chk(int'(col_o) == (250 + k) % 256, "R7 page col", int'(col_o), (250 + k) % 256);
            if (k == 299) stop_i = 1'b1;
            @(negedge clk);
        end
        stop_i = 1'b0;
        chk(!valid_o, "R8 stop ends page burst", int'(valid_o), 0);

        // Stop while idle has no effect
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk(!valid_o, "R8 stop idle", int'(valid_o), 0);

        // Stop in mid fixed burst
        launch(5, 3, 0);
        @(negedge clk);
        chk(int'(col_o) == 6, "R5 beat1", int'(col_o), 6);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk(!valid_o, "R8 stop mid burst", int'(valid_o), 0);

        // Restart during a burst
        launch(8'h10, 3, 0);
        @(negedge clk);
        @(negedge clk);
        chk(int'(col_o) == 8'h12, "R5 beat2 before restart", int'(col_o), 8'h12);
        launch(8'h33, 2, 1);
        chk(valid_o && int'(col_o) == 8'h33, "R9 restart col", int'(col_o), 8'h33);
        @(negedge clk);
        chk(int'(col_o) == 8'h32, "R9 restart beat1", int'(col_o), 8'h32);
        @(negedge clk);
        chk(int'(col_o) == 8'h31, "R9 restart beat2", int'(col_o), 8'h31);
        @(negedge clk);
        chk(int'(col_o) == 8'h30 && last_o, "R9 restart last", int'(col_o), 8'h30);
        @(negedge clk);
        chk(!valid_o, "R9 restart ends", int'(valid_o), 0);

        // Start and stop in the same cycle: start wins
        stop_i = 1'b1;
        launch(8'h7e, 1, 0);
        stop_i = 1'b0;
        chk(valid_o && int'(col_o) == 8'h7e, "R9 start beats stop", int'(col_o), 8'h7e);
        @(negedge clk);
        chk(int'(col_o) == 8'h7f && last_o, "R4 two-beat last", int'(col_o), 8'h7f);
        @(negedge clk);
        chk(!valid_o, "R4 two-beat end", int'(valid_o), 0);

        finish_run();
    end

endmodule